// File: doc/BRIEF.md
# Character Display Fetch Intercept

This block sits between a Z80-style processor bus and memory in a character-mapped video system. The processor is made to run through the display file as though it were code. Each opcode fetch whose address lies in the upper half of memory, whose byte has bit 6 clear and which happens while the processor is not halted is taken as display data. The processor receives a no-operation byte instead of the memory byte, and the character code is kept.

During the refresh slot that follows the fetch, the processor drives its refresh address onto the bus. The block ORs the high byte of that address, the character code times eight and a 3-bit scan-line number to form a character-generator address. It issues a single pattern read when that address is below the ROM/RAM boundary. The returned pattern is inverted or left as it is, according to bit 7 of the character. It is loaded into a shift register and sent out one pixel per pixel-clock enable. A line interrupt is raised while refresh is active and bit 6 of the refresh address is low.

Top module: `chr_fetch_intercept`

## Requirements
- R1: The block returns the memory byte unchanged to the processor in these cases: any cycle that is not an opcode fetch, and any opcode fetch whose address bit 15 is 0, whose byte bit 6 is 1, or that happens while halt is active.
- R2: An opcode fetch with address bit 15 = 1, byte bit 6 = 0 and halt inactive returns 0x00 to the processor.
- R3: During refresh, the pattern address is the OR of three terms: (refresh address & 0xFF00), (kept byte bits 5:0) << 3, and the 3-bit scan-line number.
- R4: A pattern read is issued only when the pattern address is strictly below the BOUNDARY parameter (default 0x4000). A qualifying fetch whose address is at or above the boundary loads no pattern.
- R5: The loaded pixel byte is the pattern XOR a mask. The mask is 0x00 when the kept byte's bit 7 is 1, and 0xFF when that bit is 0.
- R6: The pixel byte is loaded on the clock edge after the one on which the pattern read was issued. pix_out shows bit 7 first and shifts left by one, filling with 0, on each edge where pix_ce is high. It holds when pix_ce is low.
- R7: line_irq is high exactly while refresh is active and refresh-address bit 6 is 0.
- R8: An opcode fetch stretched over several cycles by wait states is intercepted in every one of those cycles. It still produces exactly one pattern read.
- R9: Each intercepted fetch produces at most one pattern read, in the first refresh cycle after it. A fetch that is not intercepted produces none.
- R10: After reset, pat_rd and pix_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address; carries the refresh address during refresh |
| mem_rdata | input | 8 | Byte read from memory in the current cycle |
| m1_act | input | 1 | Opcode-fetch cycle active, including wait extension |
| rfsh_act | input | 1 | Refresh cycle active |
| halt_act | input | 1 | Processor halt status |
| scan_line | input | 3 | Scan line within the character row |
| pix_ce | input | 1 | Pixel clock enable |
| pat_rdata | input | 8 | Pattern byte, valid one cycle after pat_rd |
| cpu_rdata | output | 8 | Byte returned to the processor |
| pat_addr | output | 16 | Character-generator address |
| pat_rd | output | 1 | Pattern read strobe |
| pix_out | output | 1 | Serial pixel output |
| line_irq | output | 1 | Line interrupt request |

## Verification
The assertions check the following on every cycle: the data substitution and pass-through, that a pattern read only happens during refresh and below the boundary, that a read is never followed by a second one, that the interrupt is tied to refresh, and that the shifter moves one place per enable. The pixel values that come out of the correct glyph, the inversion by bit 7, the wait-stretched fetch and the boundary edges at 0x3FFF and 0x4000 can only be shown by the bench scenarios, which compare full fetch-and-refresh sequences against expected values.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int LINE_W = 3;
    parameter int CODE_W = 6;

    localparam int ADDR_MSB   = ADDR_W - 1;
    localparam int GAP_BIT    = 6;   // byte bit that marks display data when clear
    localparam int INV_BIT    = 7;   // byte bit that selects the mask
    localparam int RFSH_IRQ_B = 6;   // refresh address bit that gates the interrupt
    localparam int PAGE_LSB   = DATA_W;

    typedef struct packed {
        logic              inv;
        logic [CODE_W-1:0] code;
    } glyph_sel_t;

    function automatic logic [DATA_W-1:0] nop_byte();
        return '0;
    endfunction

    function automatic logic [ADDR_W-1:0] make_pat_addr(
        input logic [ADDR_W-1:0] rfsh,
        input logic [CODE_W-1:0] code,
        input logic [LINE_W-1:0] line
    );
        logic [ADDR_W-1:0] page;
        page = rfsh & ~ADDR_W'({PAGE_LSB{1'b1}});
        return page | (ADDR_W'(code) << LINE_W) | ADDR_W'(line);
    endfunction

    function automatic logic [DATA_W-1:0] glyph_mask(input logic inv_n);
        return inv_n ? '0 : '1;
    endfunction
endpackage

// File: rtl/cfi_fetch_decode.sv
module cfi_fetch_decode
    import cfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              m1_act,
    input  logic              rfsh_act,
    input  logic              halt_act,
    output logic [DATA_W-1:0] cpu_rdata,
    output glyph_sel_t        sel_q,
    output logic              armed_q
);
    logic hit;

    always_comb begin
        hit = m1_act && bus_addr[ADDR_MSB] && !mem_rdata[GAP_BIT] && !halt_act;
        cpu_rdata = hit ? nop_byte() : mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (m1_act) begin
                armed_q <= hit;
                if (hit) begin
                    sel_q.inv  <= mem_rdata[INV_BIT];
                    sel_q.code <= mem_rdata[CODE_W-1:0];
                end
            end else if (rfsh_act) begin
                armed_q <= 1'b0;
            end
        end
    end

    AST_ARM_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> armed_q); // R8
    AST_DISARM_RFSH: assert property (@(posedge clk) disable iff (rst)
        (rfsh_act && !m1_act) |=> !armed_q); // R9
endmodule

// File: rtl/cfi_pattern_addr.sv
module cfi_pattern_addr
    import cfi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BOUNDARY = 16'h4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rfsh_act,
    input  logic [LINE_W-1:0] scan_line,
    input  glyph_sel_t        sel_q,
    input  logic              armed_q,
    output logic [ADDR_W-1:0] pat_addr,
    output logic              pat_rd,
    output logic              load_q,
    output logic              inv_q
);
    logic below;

    always_comb begin
        pat_addr = make_pat_addr(bus_addr, sel_q.code, scan_line);
        below    = pat_addr < BOUNDARY;
        pat_rd   = rfsh_act && armed_q && below;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= 1'b0;
            inv_q  <= 1'b0;
        end else begin
            load_q <= pat_rd;
            if (pat_rd) inv_q <= sel_q.inv;
        end
    end

    AST_RD_BELOW: assert property (@(posedge clk) disable iff (rst)
        pat_rd |-> (pat_addr < BOUNDARY)); // R4
    AST_RD_IN_RFSH: assert property (@(posedge clk) disable iff (rst)
        pat_rd |-> rfsh_act); // R9
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pat_rd |=> !pat_rd); // R9
    AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pat_rd |=> load_q); // R6
endmodule

// File: rtl/cfi_pixel_shift.sv
module cfi_pixel_shift
    import cfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_q,
    input  logic              inv_q,
    input  logic [DATA_W-1:0] pat_rdata,
    input  logic              pix_ce,
    output logic              pix_out
);
    logic [DATA_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load_q) begin
            sreg <= pat_rdata ^ glyph_mask(inv_q);
        end else if (pix_ce) begin
            sreg <= {sreg[DATA_W-2:0], 1'b0};
        end
    end

    assign pix_out = sreg[DATA_W-1];

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_q && pix_ce) |=> (pix_out == $past(sreg[DATA_W-2]))); // R6
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_q && !pix_ce) |=> $stable(pix_out)); // R6
endmodule

// File: rtl/chr_fetch_intercept.sv
module chr_fetch_intercept
    import cfi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BOUNDARY = 16'h4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              m1_act,
    input  logic              rfsh_act,
    input  logic              halt_act,
    input  logic [LINE_W-1:0] scan_line,
    input  logic              pix_ce,
    input  logic [DATA_W-1:0] pat_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] pat_addr,
    output logic              pat_rd,
    output logic              pix_out,
    output logic              line_irq
);
    glyph_sel_t sel_q;
    logic       armed_q;
    logic       load_q;
    logic       inv_q;

    cfi_fetch_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .mem_rdata (mem_rdata),
        .m1_act    (m1_act),
        .rfsh_act  (rfsh_act),
        .halt_act  (halt_act),
        .cpu_rdata (cpu_rdata),
        .sel_q     (sel_q),
        .armed_q   (armed_q)
    );

    cfi_pattern_addr #(.BOUNDARY(BOUNDARY)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .rfsh_act  (rfsh_act),
        .scan_line (scan_line),
        .sel_q     (sel_q),
        .armed_q   (armed_q),
        .pat_addr  (pat_addr),
        .pat_rd    (pat_rd),
        .load_q    (load_q),
        .inv_q     (inv_q)
    );

    cfi_pixel_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load_q    (load_q),
        .inv_q     (inv_q),
        .pat_rdata (pat_rdata),
        .pix_ce    (pix_ce),
        .pix_out   (pix_out)
    );

    assign line_irq = rfsh_act && !bus_addr[RFSH_IRQ_B];

    AST_PASS_NON_M1: assert property (@(posedge clk) disable iff (rst)
        !m1_act |-> (cpu_rdata == mem_rdata)); // R1
    AST_NOP_ON_DISPLAY: assert property (@(posedge clk) disable iff (rst)
        (m1_act && bus_addr[ADDR_MSB] && !mem_rdata[GAP_BIT] && !halt_act)
        |-> (cpu_rdata == '0)); // R2
    AST_IRQ_IN_RFSH: assert property (@(posedge clk) disable iff (rst)
        line_irq |-> rfsh_act); // R7
endmodule

// File: tb/chr_fetch_intercept_bench.sv
module chr_fetch_intercept_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic [7:0]  mem_rdata;
    logic        m1_act, rfsh_act, halt_act, pix_ce;
    logic [2:0]  scan_line;
    logic [7:0]  pat_rdata;
    logic [7:0]  cpu_rdata;
    logic [15:0] pat_addr;
    logic        pat_rd, pix_out, line_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chr_fetch_intercept u_chr_fetch_intercept (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .mem_rdata(mem_rdata),
        .m1_act(m1_act), .rfsh_act(rfsh_act), .halt_act(halt_act),
        .scan_line(scan_line), .pix_ce(pix_ce), .pat_rdata(pat_rdata),
        .cpu_rdata(cpu_rdata), .pat_addr(pat_addr), .pat_rd(pat_rd),
        .pix_out(pix_out), .line_irq(line_irq)
    );

    function automatic logic [7:0] rom_val(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
    endfunction

    always @(posedge clk) if (pat_rd) pat_rdata <= rom_val(pat_addr);

    function automatic bit exp_hit(input logic [15:0] a, input logic [7:0] d, input logic h);
        return a[15] && !d[6] && !h;
    endfunction

    function automatic logic [15:0] exp_paddr(input logic [15:0] r, input logic [7:0] d,
                                              input logic [2:0] l);
        return {r[15:8], 8'h00} | {7'b0, d[5:0], 3'b0} | {13'b0, l};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        m1_act = 0; rfsh_act = 0; pix_ce = 0;
    endtask

    // one opcode fetch of 1+waits cycles, then two refresh cycles, then pixels
    task automatic fetch_line(input logic [15:0] a, input logic [7:0] d, input logic h,
                              input int waits, input logic [15:0] r, input logic [2:0] l);
        bit hit;
        bit want;
        logic [15:0] pa;
        logic [7:0] pix;
        hit = exp_hit(a, d, h);
        pa  = exp_paddr(r, d, l);
        want = hit && (pa < 16'h4000);
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            m1_act = 1; rfsh_act = 0; bus_addr = a; mem_rdata = d; halt_act = h;
            scan_line = l; pix_ce = 0;
            #1;
            chk(hit ? "R2/R8" : "R1", cpu_rdata, hit ? 8'h00 : d);
        end
        @(negedge clk);
        m1_act = 0; rfsh_act = 1; bus_addr = r; mem_rdata = 8'hFF;
        #1;
        chk("R9 first refresh", pat_rd, want);
        if (want) chk("R3", pat_addr, pa);
        chk("R7", line_irq, !r[6]);
        @(negedge clk);
        #1;
        chk("R9 second refresh", pat_rd, 0);
        chk("R7", line_irq, !r[6]);
        @(negedge clk);
        rfsh_act = 0; bus_addr = 16'h0000;
        #1;
        chk("R7 idle", line_irq, 0);
        pix = want ? (rom_val(pa) ^ (d[7] ? 8'h00 : 8'hFF)) : 8'h00;
        chk("R6 hold", pix_out, pix[7]);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            pix_ce = 1;
            #1;
            chk(want ? "R5/R6" : "R4/R9", pix_out, pix[i]);
            @(posedge clk);
        end
        idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, r;
        logic [7:0] d;
        logic h;
        void'($urandom(32'd2024));
        rst = 1; bus_addr = 0; mem_rdata = 0; m1_act = 0; rfsh_act = 0;
        halt_act = 0; scan_line = 0; pix_ce = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 pat_rd", pat_rd, 0);
        chk("R10 pix_out", pix_out, 0);
        @(negedge clk);
        rst = 0;
        // directed corners
        fetch_line(16'h8123, 8'h05, 0, 0, 16'h1E20, 3'd2);  // invert, irq
        fetch_line(16'h8123, 8'h85, 0, 0, 16'h1E60, 3'd7);  // no invert, no irq
        fetch_line(16'h8123, 8'hBF, 0, 0, 16'h3F00, 3'd7);  // 0x3FFF: below
        fetch_line(16'hC000, 8'h00, 0, 0, 16'h4000, 3'd0);  // 0x4000: at boundary
        fetch_line(16'h0123, 8'h05, 0, 0, 16'h1E00, 3'd1);  // addr bit 15 clear
        fetch_line(16'h8123, 8'h45, 0, 0, 16'h1E00, 3'd1);  // byte bit 6 set
        fetch_line(16'h8123, 8'h05, 1, 0, 16'h1E00, 3'd1);  // halted
        fetch_line(16'h9000, 8'h2A, 0, 3, 16'h2100, 3'd4);  // wait-stretched
        // non-fetch read of display-like byte passes through
        @(negedge clk);
        bus_addr = 16'h8000; mem_rdata = 8'h05; #1;
        chk("R1 non-fetch", cpu_rdata, 8'h05);
        idle();
        // random mix
        for (int n = 0; n < 300; n++) begin
            a = 16'($urandom);
            d = 8'($urandom);
            h = ($urandom % 6) == 0;
            r = {($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 64), 8'($urandom)};
            fetch_line(a, d, h, int'($urandom % 3), r, 3'($urandom));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule